// File: doc/BRIEF.md
# Audio Master Clock Output Sequencer

This block produces the bit clock, frame clock and master clock outputs of an audio serial port that runs as clock master. It runs from one internal clock at 256 times the sample rate. It also receives a PLL lock flag, a power/enable bit, a master-clock-out enable, a two-bit serial format select and two polarity bits. While the port is disabled, or the PLL has not yet locked, the bit and frame clocks are held low. When lock arrives, framing starts cleanly at the beginning of a left-channel frame. The bit clock is the internal clock divided by four (64fs).

In the two DSP formats, one pair of settings shortens the first bit-clock high phase after start-up by one internal clock. This happens when the MSB-position bit and the bit-clock polarity bit differ. The master clock output is a divided copy of the internal clock, enabled separately. The intended use is to clear the enable bit before any sample-rate change, so that no undefined clocks leave the chip while the PLL relocks.

Top module: `aclk_master_seq`

## Requirements
- R1: While `pwr_en_i` or `pll_lock_i` is low at a rising clock edge, `bclk_o` and `lrck_o` are low after that edge.
- R2: If enable or lock drops while framing runs, both clocks are low after the next edge. When both are high again, framing restarts from a fresh left-channel frame.
- R3: When `pwr_en_i` and `mcko_en_i` are both high at an edge, `mcko_o` toggles at that edge (a 128fs square wave). At any other edge it goes low.
- R4: In the first cycle after enable and lock are both seen high, `lrck_o` is high. LRCK high marks the left channel.
- R5: Framing cycles are counted from 0 at start. The bit clock period is 4 cycles. With `bckp_i`=0, `bclk_o` is high in counts 0 and 1 of each group of four. With `bckp_i`=1, it is high in counts 2 and 3.
- R6: `lrck_o` is high for the first half of a period and low for the second half. The period is 256 cycles (fs) for `fmt_i` 2'b00, 2'b01 and 2'b11, and 128 cycles (2fs) for `fmt_i`=2'b10 (DSP mode 1).
- R7: With `fmt_i` not 2'b00 and `msbs_i` != `bckp_i`, the first bit-clock high phase after a start lasts 1 cycle, because its first cycle is held low. Later high phases, and all high phases under other settings, last 2 cycles.
- R8: Synchronous active-low `rst_ni` forces all three outputs low after the edge and clears the dividers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, 256 times the sample rate |
| rst_ni | input | 1 | Synchronous active-low reset |
| pwr_en_i | input | 1 | Power/enable for clock generation |
| pll_lock_i | input | 1 | PLL lock indication |
| mcko_en_i | input | 1 | Master clock output enable |
| fmt_i | input | 2 | Serial format: 00 standard, 01 DSP0, 10 DSP1, 11 DSP0 |
| msbs_i | input | 1 | MSB position select for DSP formats |
| bckp_i | input | 1 | Bit clock polarity |
| bclk_o | output | 1 | Bit clock, 64fs |
| lrck_o | output | 1 | Frame clock, high for left channel |
| mcko_o | output | 1 | Master clock output |

## Verification
If the frame counter is wrong at start, LRCK goes high in the wrong cycle or with the wrong width. This shows within one frame, and a false start shows in the very first cycle after lock. If the run flag is stale, the clocks keep toggling in the cycle after lock drops, and the fault is visible one edge after the drop. If the first-phase flag is mishandled, it affects only the one or two cycles of the first bit-clock high phase after each start. So every start-up under each polarity and format pair is compared cycle by cycle against an independently computed waveform.

// File: rtl/aclk_seq_pkg.sv
package aclk_seq_pkg;

    typedef enum logic [1:0] {
        FMT_STD      = 2'b00,
        FMT_DSP0     = 2'b01,
        FMT_DSP1     = 2'b10,
        FMT_DSP0_ALT = 2'b11
    } fmt_e;

endpackage

// File: rtl/aclk_seq_ctrl.sv
module aclk_seq_ctrl #(
    parameter int CNT_W    = 8,
    parameter int BCLK_LOG = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pwr_en_i,
    input  logic             pll_lock_i,
    output logic             run_d_o,
    output logic             first_d_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             run_q_o,
    output logic [CNT_W-1:0] cnt_q_o
);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(2 ** BCLK_LOG);

    typedef struct packed {
        logic             run;
        logic             first;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + 1'b1;
        if (pwr_en_i && pll_lock_i) begin
            if (!st_q.run) begin
                st_d.run   = 1'b1;
                st_d.first = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = cnt_inc;
                if (cnt_inc >= WIN_C) begin
                    st_d.first = 1'b0;
                end
            end
        end else begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_d_o   = st_d.run;
    assign first_d_o = st_d.first;
    assign cnt_d_o   = st_d.cnt;
    assign run_q_o   = st_q.run;
    assign cnt_q_o   = st_q.cnt;

    assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && pwr_en_i && pll_lock_i) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    assert_start_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.run) |-> (st_q.cnt == '0 && st_q.first));

endmodule

// File: rtl/aclk_edge_gen.sv
module aclk_edge_gen
    import aclk_seq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int BCLK_LOG = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             first_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       fmt_i,
    input  logic             msbs_i,
    input  logic             bckp_i,
    output logic             bclk_o,
    output logic             lrck_o
);
    localparam int               HALF_C     = 2 ** (BCLK_LOG - 1);
    localparam logic [CNT_W-1:0] SUB_MASK_C = CNT_W'(HALF_C - 1);

    typedef struct packed {
        logic bclk;
        logic lrck;
    } out_t;

    out_t out_d, out_q;
    logic base_hi, dsp_fmt, trim, lr_bit;

    always_comb begin
        base_hi = bckp_i ? cnt_i[BCLK_LOG-1] : ~cnt_i[BCLK_LOG-1];
        dsp_fmt = (fmt_e'(fmt_i) != FMT_STD);
        trim    = dsp_fmt && (msbs_i ^ bckp_i) && first_i && base_hi
                  && ((cnt_i & SUB_MASK_C) == '0);
        lr_bit  = (fmt_e'(fmt_i) == FMT_DSP1) ? cnt_i[CNT_W-2] : cnt_i[CNT_W-1];
        out_d.bclk = run_i && base_hi && !trim;
        out_d.lrck = run_i && !lr_bit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bclk_o = out_q.bclk;
    assign lrck_o = out_q.lrck;

endmodule

// File: rtl/aclk_mclk_out.sv
module aclk_mclk_out (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic mcko_o
);
    typedef struct packed {
        logic mck;
    } mck_t;

    mck_t mck_d, mck_q;

    always_comb begin
        mck_d.mck = en_i ? ~mck_q.mck : 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mck_q <= '0;
        end else begin
            mck_q <= mck_d;
        end
    end

    assign mcko_o = mck_q.mck;

    assert_mcko_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (mcko_o != $past(mcko_o)));

endmodule

// File: rtl/aclk_master_seq.sv
module aclk_master_seq #(
    parameter int CNT_W    = 8,
    parameter int BCLK_LOG = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwr_en_i,
    input  logic       pll_lock_i,
    input  logic       mcko_en_i,
    input  logic [1:0] fmt_i,
    input  logic       msbs_i,
    input  logic       bckp_i,
    output logic       bclk_o,
    output logic       lrck_o,
    output logic       mcko_o
);
    logic             run_d, first_d, run_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    aclk_seq_ctrl #(.CNT_W(CNT_W), .BCLK_LOG(BCLK_LOG)) i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pwr_en_i   (pwr_en_i),
        .pll_lock_i (pll_lock_i),
        .run_d_o    (run_d),
        .first_d_o  (first_d),
        .cnt_d_o    (cnt_d),
        .run_q_o    (run_q),
        .cnt_q_o    (cnt_q)
    );

    aclk_edge_gen #(.CNT_W(CNT_W), .BCLK_LOG(BCLK_LOG)) i_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_d),
        .first_i (first_d),
        .cnt_i   (cnt_d),
        .fmt_i   (fmt_i),
        .msbs_i  (msbs_i),
        .bckp_i  (bckp_i),
        .bclk_o  (bclk_o),
        .lrck_o  (lrck_o)
    );

    aclk_mclk_out i_mclk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (pwr_en_i && mcko_en_i),
        .mcko_o (mcko_o)
    );

    assert_gate_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwr_en_i || !pll_lock_i) |=> (!bclk_o && !lrck_o));

    assert_mcko_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwr_en_i || !mcko_en_i) |=> !mcko_o);

    assert_left_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && cnt_q == '0) |-> lrck_o);

    assert_bclk_needs_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclk_o |-> run_q);

    assert_first_short_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(run_q) && fmt_i != 2'b00 && msbs_i && !bckp_i) |-> !bclk_o);

    assert_reset_R8: assert property (@(posedge clk_i)
        !rst_ni |=> (!bclk_o && !lrck_o && !mcko_o));

endmodule

// File: tb/test_aclk_master_seq.sv
module test_aclk_master_seq;
    logic       clk = 1'b0;
    logic       rst_n, pwr, lock, mck_en, msbs, bckp;
    logic [1:0] fmt;
    logic       bclk, lrck, mcko;
    int         n_chk = 0;
    int         n_fail = 0;

    bit r_run, r_first, r_mck, prev_run;
    int r_cnt;

    always #10 clk = ~clk;

    aclk_master_seq i_aclk_master_seq (
        .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr), .pll_lock_i(lock),
        .mcko_en_i(mck_en), .fmt_i(fmt), .msbs_i(msbs), .bckp_i(bckp),
        .bclk_o(bclk), .lrck_o(lrck), .mcko_o(mcko)
    );

    // reference model driven by the requirement text
    always @(posedge clk) begin
        if (!rst_n) begin
            r_run = 0; r_first = 0; r_cnt = 0; r_mck = 0;
        end else begin
            r_mck = (pwr && mck_en) ? ~r_mck : 1'b0;
            if (pwr && lock) begin
                if (!r_run) begin
                    r_run = 1; r_first = 1; r_cnt = 0;
                end else begin
                    r_cnt = (r_cnt + 1) % 256;
                    if (r_cnt >= 4) r_first = 0;
                end
            end else begin
                r_run = 0; r_first = 0; r_cnt = 0;
            end
        end
    end

    function automatic bit exp_bclk();
        bit base, trim;
        if (!r_run) return 1'b0;
        base = bckp ? bit'((r_cnt >> 1) & 1) : !bit'((r_cnt >> 1) & 1);
        trim = (fmt != 2'b00) && (msbs != bckp) && r_first && base && (r_cnt % 2 == 0);
        return base && !trim;
    endfunction

    function automatic bit exp_lrck();
        int half;
        half = (fmt == 2'b10) ? 64 : 128;
        return r_run && ((r_cnt % (2 * half)) < half);
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (cnt %0d fmt %b msbs %b bckp %b)",
                     tag, what, act, exp, r_cnt, fmt, msbs, bckp);
        end
    endtask

    task automatic step();
        string tb_tag, tl_tag;
        @(negedge clk);
        if (!rst_n || !$isunknown(rst_n) && r_run == 0 && !rst_n) tb_tag = "R8";
        if (!rst_n) begin
            tb_tag = "R8"; tl_tag = "R8";
        end else if (!r_run) begin
            tb_tag = prev_run ? "R2" : "R1"; tl_tag = tb_tag;
        end else begin
            tb_tag = (r_first && fmt != 2'b00) ? "R7" : "R5";
            tl_tag = (r_cnt == 0) ? "R4" : "R6";
        end
        check(tb_tag, "bclk", bclk, exp_bclk());
        check(tl_tag, "lrck", lrck, exp_lrck());
        check(rst_n ? "R3" : "R8", "mcko", mcko, r_mck);
        prev_run = r_run;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20517);
        rst_n = 0; pwr = 1; lock = 1; mck_en = 1; fmt = 2'b01; msbs = 0; bckp = 1;
        prev_run = 0;
        repeat (3) step();                       // R8 reset state
        rst_n = 1; lock = 0;
        for (int i = 0; i < 40; i++) begin       // R1 gating with random bits
            step();
            pwr = 1'($urandom); mck_en = 1'($urandom);
            fmt = 2'($urandom); msbs = 1'($urandom); bckp = 1'($urandom);
        end
        for (int cfg = 0; cfg < 16; cfg++) begin
            int drop_at;
            fmt = cfg[3:2]; msbs = cfg[1]; bckp = cfg[0];
            pwr = 1; lock = 0;
            repeat (3) step();
            lock = 1;
            drop_at = 100 + int'($urandom % 100);
            for (int c = 0; c < 300; c++) begin
                step();
                if (c % 37 == 0) mck_en = 1'($urandom);
                if (c == drop_at) begin
                    if (cfg[0]) lock = 0; else pwr = 0;   // R2 drop
                end
                if (c == drop_at + 1 + int'($urandom % 3)) begin
                    lock = 1; pwr = 1;
                end
            end
            pwr = 0;
            step();
        end
        // R8 reset while running
        pwr = 1; lock = 1; mck_en = 1; fmt = 2'b10;
        repeat (20) step();
        rst_n = 0;
        repeat (2) step();
        rst_n = 1;
        repeat (10) step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule